// File: doc/BRIEF.md
# DMA Channel Status Tracker

This block keeps the status of a single DMA channel. At a start request it checks the programmed byte count, source address and destination address against the requested transfer size. It then steps through the request, busy and done phases as the arbiter selects the channel and as the data mover reports completed beats. It records bus errors from the read phase and from the write phase, and it drives an interrupt while the channel reports done.

Software reads an 8-bit status word through a simple register port. Writing a one to the done bit clears every flag in a single write. The same write aborts the channel if it is still running. The address and count registers and the data mover sit outside this block. Their values arrive on input ports, and a remaining-byte counter is loaded from them when a transfer is accepted.

Top module: `dma_chan_status`

## Requirements
- R1: After reset every status bit reads 0, `active_o` is 0 and `remain_o` is 0. The status bit map is: configuration error at bit 6, source bus error at bit 5, destination bus error at bit 4, request at bit 2, busy at bit 1 and done at bit 0. Bits 7 and 3 always read 0.
- R2: A start with a zero byte count, with size code 3, or with a source address, destination address or byte count not a multiple of the beat size produces status 0x41 (configuration error and done). The channel never becomes active. Size codes: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes.
- R3: An accepted start with no grant in the same cycle produces status 0x04 (request), sets `active_o` and loads `remain_o` with the byte count.
- R4: The request bit is 0 in the cycle after `grant_i` is high. While bytes remain and the grant is low, it reads 1 again.
- R5: The busy bit sets with the first grant after a start. It stays set while the grant drops and returns, and it clears when the transfer ends.
- R6: Each `wr_ack_i` beat of an active channel lowers `remain_o` by the beat size. The beat that brings it to zero ends the transfer with status 0x01.
- R7: `rd_err_i` on an active channel ends it with status 0x21. `wr_err_i` ends it with status 0x11. Both together give 0x31.
- R8: A register write with data bit 0 = 1 clears all flags and `remain_o` and stops the channel. A write with bit 0 = 0 changes nothing, whatever the other data bits are.
- R9: A clearing register write takes priority over every hardware event in the same cycle, so the status reads 0x00 afterwards.
- R10: A start request while done is set, or while the channel is active, leaves the status and `remain_o` unchanged.
- R11: `irq_o` equals done AND `irq_en_i`.
- R12: Beat acknowledges and bus errors while the channel is inactive have no effect on the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request pulse |
| size_i | input | 2 | Beat size code (0: 1 B, 1: 2 B, 2: 4 B, 3: invalid) |
| src_addr_i | input | AW | Programmed source address |
| dst_addr_i | input | AW | Programmed destination address |
| byte_cnt_i | input | CW | Programmed byte count |
| grant_i | input | 1 | Channel selected by the arbiter |
| rd_err_i | input | 1 | Bus error in the read phase |
| wr_ack_i | input | 1 | Beat completed in the write phase |
| wr_err_i | input | 1 | Bus error in the write phase |
| reg_wr_i | input | 1 | Status register write strobe |
| reg_wdata_i | input | 8 | Status register write data |
| irq_en_i | input | 1 | Interrupt enable |
| reg_rdata_o | output | 8 | Status register value |
| irq_o | output | 1 | Interrupt request |
| remain_o | output | CW | Bytes left in the transfer |
| active_o | output | 1 | Channel may issue bus accesses |

## Verification
The assertions check, on every cycle, the invariants between flags: the reserved bits read zero, busy and request only appear while the channel is active, a configuration error never coexists with an active channel, done never coexists with busy, a clearing write always zeroes the word, and the counter never underflows. Only the bench's scenarios can show the exact status words and byte counts for each size, alignment and count combination. The same holds for the order of the request, busy and done phases, the error termination codes, and the cases where a start or a write is ignored.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } beat_size_e;

    localparam int ST_CFG  = 6;
    localparam int ST_SERR = 5;
    localparam int ST_DERR = 4;
    localparam int ST_REQ  = 2;
    localparam int ST_BUSY = 1;
    localparam int ST_DONE = 0;

    typedef struct packed {
        logic cfg;
        logic serr;
        logic derr;
        logic req;
        logic busy;
        logic done;
        logic run;
    } chan_flags_t;

    function automatic logic [2:0] beat_bytes(input beat_size_e sz);
        case (sz)
            SZ_BYTE: beat_bytes = 3'd1;
            SZ_HALF: beat_bytes = 3'd2;
            SZ_WORD: beat_bytes = 3'd4;
            default: beat_bytes = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/dcs_cfg_check.sv
module dcs_cfg_check
    import dcs_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic [1:0]    size_i,
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] dst_i,
    input  logic [CW-1:0] cnt_i,
    output logic [2:0]    step_o,
    output logic          cfg_err_o
);
    localparam int NOPS = 3;

    logic [NOPS-1:0][1:0] low;
    logic [NOPS-1:0]      misal;
    logic [1:0]           mask;
    beat_size_e           sz;

    assign sz     = beat_size_e'(size_i);
    assign step_o = beat_bytes(sz);
    assign mask   = step_o[1:0] - 2'd1;

    assign low[0] = src_i[1:0];
    assign low[1] = dst_i[1:0];
    assign low[2] = cnt_i[1:0];

    for (genvar g = 0; g < NOPS; g++) begin : g_align
        assign misal[g] = |(low[g] & mask);
    end

    assign cfg_err_o = (cnt_i == '0) || (sz == SZ_BAD) || (|misal);

endmodule

// File: rtl/dcs_beat_ctr.sv
module dcs_beat_ctr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          dec_i,
    input  logic [2:0]    amt_i,
    output logic [CW-1:0] remain_o,
    output logic          last_o
);
    logic [CW-1:0] remain_d, remain_q;

    always_comb begin
        remain_d = remain_q;
        if (clr_i)
            remain_d = '0;
        else if (load_i)
            remain_d = load_val_i;
        else if (dec_i)
            remain_d = remain_q - CW'(amt_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain_q <= '0;
        else
            remain_q <= remain_d;
    end

    assign remain_o = remain_q;
    assign last_o   = (remain_q == CW'(amt_i));

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !clr_i && !load_i) |-> (remain_q >= CW'(amt_i))) else $error("underflow"); // R6

endmodule

// File: rtl/dcs_flags.sv
module dcs_flags
    import dcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       cfg_err_i,
    input  logic       grant_i,
    input  logic       rd_err_i,
    input  logic       wr_ack_i,
    input  logic       wr_err_i,
    input  logic       last_i,
    input  logic       sw_wr_i,
    input  logic [7:0] sw_wdata_i,
    output logic [7:0] status_o,
    output logic       run_o,
    output logic       load_o,
    output logic       dec_o,
    output logic       clr_o
);
    chan_flags_t flg_d, flg_q;
    logic sw_clr, accept, bus_err, fin_ok, ended;

    always_comb begin
        sw_clr  = sw_wr_i && sw_wdata_i[ST_DONE];
        accept  = start_i && !flg_q.done && !flg_q.run;
        bus_err = rd_err_i || wr_err_i;
        fin_ok  = wr_ack_i && last_i && !bus_err;
        ended   = flg_q.run && (bus_err || fin_ok);

        flg_d = flg_q;
        if (flg_q.run) begin
            if (rd_err_i) flg_d.serr = 1'b1;
            if (wr_err_i) flg_d.derr = 1'b1;
            if (bus_err || fin_ok) begin
                flg_d.run  = 1'b0;
                flg_d.busy = 1'b0;
                flg_d.req  = 1'b0;
                flg_d.done = 1'b1;
            end else begin
                flg_d.busy = flg_q.busy || grant_i;
                flg_d.req  = !grant_i;
            end
        end else if (accept) begin
            if (cfg_err_i) begin
                flg_d.cfg  = 1'b1;
                flg_d.done = 1'b1;
            end else begin
                flg_d.run  = 1'b1;
                flg_d.busy = grant_i;
                flg_d.req  = !grant_i;
            end
        end
        if (sw_clr)
            flg_d = '0;

        load_o = accept && !cfg_err_i && !sw_clr;
        dec_o  = flg_q.run && wr_ack_i;
        clr_o  = sw_clr || ended;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flg_q <= '0;
        else
            flg_q <= flg_d;
    end

    always_comb begin
        status_o          = '0;
        status_o[ST_CFG]  = flg_q.cfg;
        status_o[ST_SERR] = flg_q.serr;
        status_o[ST_DERR] = flg_q.derr;
        status_o[ST_REQ]  = flg_q.req;
        status_o[ST_BUSY] = flg_q.busy;
        status_o[ST_DONE] = flg_q.done;
    end
    assign run_o = flg_q.run;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[7] == 1'b0) && (status_o[3] == 1'b0)) else $error("reserved"); // R1
    AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        grant_i |=> !flg_q.req) else $error("req"); // R4
    AST_BUSY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_q.busy || flg_q.req) |-> flg_q.run) else $error("busy"); // R5
    AST_CFG_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        flg_q.cfg |-> !flg_q.run) else $error("cfg"); // R2
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        flg_q.done |-> (!flg_q.busy && !flg_q.run)) else $error("done"); // R6
    AST_W1C_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr_i && sw_wdata_i[ST_DONE]) |=> (status_o == 8'h00 && !flg_q.run)) else $error("w1c"); // R9
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_q.done && !(sw_wr_i && sw_wdata_i[ST_DONE])) |=> $stable(status_o)) else $error("hold"); // R10

endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
    import dcs_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [1:0]    size_i,
    input  logic [AW-1:0] src_addr_i,
    input  logic [AW-1:0] dst_addr_i,
    input  logic [CW-1:0] byte_cnt_i,
    input  logic          grant_i,
    input  logic          rd_err_i,
    input  logic          wr_ack_i,
    input  logic          wr_err_i,
    input  logic          reg_wr_i,
    input  logic [7:0]    reg_wdata_i,
    input  logic          irq_en_i,
    output logic [7:0]    reg_rdata_o,
    output logic          irq_o,
    output logic [CW-1:0] remain_o,
    output logic          active_o
);
    logic [2:0] step;
    logic       cfg_err, last, load, dec, clr;

    dcs_cfg_check #(.AW(AW), .CW(CW)) u_cfg (
        .size_i   (size_i),
        .src_i    (src_addr_i),
        .dst_i    (dst_addr_i),
        .cnt_i    (byte_cnt_i),
        .step_o   (step),
        .cfg_err_o(cfg_err)
    );

    dcs_beat_ctr #(.CW(CW)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr),
        .load_i    (load),
        .load_val_i(byte_cnt_i),
        .dec_i     (dec),
        .amt_i     (step),
        .remain_o  (remain_o),
        .last_o    (last)
    );

    dcs_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .cfg_err_i (cfg_err),
        .grant_i   (grant_i),
        .rd_err_i  (rd_err_i),
        .wr_ack_i  (wr_ack_i),
        .wr_err_i  (wr_err_i),
        .last_i    (last),
        .sw_wr_i   (reg_wr_i),
        .sw_wdata_i(reg_wdata_i),
        .status_o  (reg_rdata_o),
        .run_o     (active_o),
        .load_o    (load),
        .dec_o     (dec),
        .clr_o     (clr)
    );

    assign irq_o = reg_rdata_o[ST_DONE] && irq_en_i;

    AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && !start_i && !reg_wr_i) |=> $stable(remain_o)) else $error("idle cnt"); // R12

endmodule

// File: tb/dma_chan_status_test.sv
module dma_chan_status_test;
    localparam int AW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [1:0]    size_i = '0;
    logic [AW-1:0] src_addr_i = '0;
    logic [AW-1:0] dst_addr_i = '0;
    logic [CW-1:0] byte_cnt_i = '0;
    logic          grant_i = 1'b0;
    logic          rd_err_i = 1'b0;
    logic          wr_ack_i = 1'b0;
    logic          wr_err_i = 1'b0;
    logic          reg_wr_i = 1'b0;
    logic [7:0]    reg_wdata_i = '0;
    logic          irq_en_i = 1'b0;
    logic [7:0]    reg_rdata_o;
    logic          irq_o;
    logic [CW-1:0] remain_o;
    logic          active_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    dma_chan_status #(.AW(AW), .CW(CW)) uut (.*);

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [7:0] d);
        reg_wr_i = 1'b1; reg_wdata_i = d;
        tick();
        reg_wr_i = 1'b0; reg_wdata_i = '0;
    endtask

    task automatic do_start(input int sz, input int sa, input int da, input int cnt);
        start_i = 1'b1; size_i = 2'(sz);
        src_addr_i = AW'(32'h100 + sa); dst_addr_i = AW'(32'h200 + da);
        byte_cnt_i = CW'(cnt);
        tick();
        start_i = 1'b0;
    endtask

    task automatic run_case(input int sz, input int sa, input int da, input int cnt);
        int step = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 0;
        bit ce = (cnt == 0) || (step == 0) || (sa % (step == 0 ? 1 : step) != 0)
                 || (da % (step == 0 ? 1 : step) != 0) || (cnt % (step == 0 ? 1 : step) != 0);
        int beats;
        irq_en_i = (sa % 2 == 0);
        do_start(sz, sa, da, cnt);
        if (ce) begin
            chk("R2 cfg status", reg_rdata_o, 8'h41);
            chk("R2 inactive", active_o, 0);
            chk("R11 irq", irq_o, irq_en_i);
        end else begin
            beats = cnt / step;
            chk("R3 req status", reg_rdata_o, 8'h04);
            chk("R3 remain", remain_o, cnt);
            grant_i = 1'b1; tick();
            chk("R5 busy", reg_rdata_o, 8'h02);
            chk("R4 req off on grant", reg_rdata_o[2], 0);
            for (int b = 0; b < beats; b++) begin
                wr_ack_i = 1'b1; tick(); wr_ack_i = 1'b0;
                if (b < beats - 1) begin
                    chk("R6 remain", remain_o, cnt - (b + 1) * step);
                    if (b == 0 && da == 0) begin
                        grant_i = 1'b0; tick();
                        chk("R4 req back", reg_rdata_o, 8'h06);
                        grant_i = 1'b1; tick();
                        chk("R5 busy kept", reg_rdata_o, 8'h02);
                    end
                end
            end
            grant_i = 1'b0;
            chk("R6 done status", reg_rdata_o, 8'h01);
            chk("R6 remain zero", remain_o, 0);
            chk("R11 irq", irq_o, irq_en_i);
        end
        do_start(0, 0, 0, 4);
        chk("R10 start while done", reg_rdata_o, ce ? 8'h41 : 8'h01);
        chk("R10 remain", remain_o, 0);
        wr_reg(8'h01);
        chk("R8 cleared", reg_rdata_o, 8'h00);
        chk("R11 irq low", irq_o, 0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 reset status", reg_rdata_o, 8'h00);
        chk("R1 reset active", active_o, 0);
        chk("R1 reset remain", remain_o, 0);

        for (int sz = 0; sz < 4; sz++)
            for (int sa = 0; sa < 4; sa++)
                for (int da = 0; da < 4; da++)
                    for (int ci = 0; ci < 7; ci++)
                        run_case(sz, sa, da, (ci < 5) ? ci : (ci == 5 ? 6 : 12));

        // R12: events while idle
        rd_err_i = 1'b1; wr_err_i = 1'b1; wr_ack_i = 1'b1; tick();
        rd_err_i = 1'b0; wr_err_i = 1'b0; wr_ack_i = 1'b0;
        chk("R12 idle events", reg_rdata_o, 8'h00);

        // R7 read error
        do_start(2, 0, 0, 16); grant_i = 1'b1; tick();
        rd_err_i = 1'b1; tick(); rd_err_i = 1'b0; grant_i = 1'b0;
        chk("R7 read error", reg_rdata_o, 8'h21);
        chk("R7 stopped", active_o, 0);
        wr_reg(8'h01);
        // R7 write error
        do_start(1, 0, 0, 8); grant_i = 1'b1; tick();
        wr_err_i = 1'b1; tick(); wr_err_i = 1'b0; grant_i = 1'b0;
        chk("R7 write error", reg_rdata_o, 8'h11);
        wr_reg(8'h01);
        // R7 both
        do_start(0, 0, 0, 3);
        rd_err_i = 1'b1; wr_err_i = 1'b1; tick(); rd_err_i = 1'b0; wr_err_i = 1'b0;
        chk("R7 both errors", reg_rdata_o, 8'h31);
        wr_reg(8'h01);

        // R10 start while running
        do_start(2, 0, 0, 8);
        do_start(0, 0, 0, 3);
        chk("R10 start while active", remain_o, 8);
        chk("R10 status while active", reg_rdata_o, 8'h04);
        // R8 writes with bit0 clear do nothing
        wr_reg(8'hFE);
        chk("R8 zero write", reg_rdata_o, 8'h04);
        chk("R8 zero write remain", remain_o, 8);
        // R8 abort
        grant_i = 1'b1; tick();
        wr_reg(8'h01);
        chk("R8 abort status", reg_rdata_o, 8'h00);
        chk("R8 abort inactive", active_o, 0);
        wr_ack_i = 1'b1; tick(); wr_ack_i = 1'b0;
        chk("R12 beat after abort", reg_rdata_o, 8'h00);
        grant_i = 1'b0;

        // R9 clear beats hardware in same cycle
        do_start(0, 0, 0, 2);
        rd_err_i = 1'b1; reg_wr_i = 1'b1; reg_wdata_i = 8'h01; tick();
        rd_err_i = 1'b0; reg_wr_i = 1'b0; reg_wdata_i = '0;
        chk("R9 clear over error", reg_rdata_o, 8'h00);
        start_i = 1'b1; byte_cnt_i = '0; reg_wr_i = 1'b1; reg_wdata_i = 8'h01; tick();
        start_i = 1'b0; reg_wr_i = 1'b0; reg_wdata_i = '0;
        chk("R9 clear over start", reg_rdata_o, 8'h00);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule